// File: doc/BRIEF.md
# System and Bus Clock Prescaler

This block takes one source clock and produces two derived clocks from it. The first stage gives the system clock. That clock is either the source clock itself or the source divided by one and a half, which means two output periods for every three source periods. The second stage divides the system clock by a power of two, from 1 to 128, and the result is the bus clock.

Both settings sit in a single 4-bit configuration field. Software writes the field and reads it back through a simple 32-bit register port that is clocked by the source clock. The field may be rewritten while the clocks are running. Each stage picks up a new setting only at the boundary of one of its own output periods. This means a partial high or low phase never reaches the clock outputs.

The one-and-a-half stage uses one flop clocked on the rising source edge and one flop clocked on the falling source edge. The output is their exclusive-or, so every edge of the system clock coincides with a source edge. When a stage divides by one, its output is the incoming clock passed through a multiplexer, with no register in the path.

Top module: `sysbus_prescaler`

## Requirements
- R1: After reset the readback value is 0, sys_clk follows src_clk and bus_clk follows sys_clk.
- R2: With field bit 3 set to 1, sys_clk has a period of 1.5 source periods and stays high for half a source period. Its rising edges fall alternately on a rising and on a falling source edge.
- R3: With field bit 3 at 0, sys_clk equals src_clk through combinational logic, so its rising edges are the rising edges of src_clk.
- R4: With field bits 2:0 equal to k and k at least 1, bus_clk has a period of 2^k sys_clk periods and is high for the first 2^(k-1) of them.
- R5: With field bits 2:0 equal to 0, bus_clk equals sys_clk, and their rising edges coincide.
- R6: A write with wr_en high is taken on the rising edge of src_clk. rd_data returns the stored field in bits 3:0, and bits 31:4 read as 0 whatever value was written to them.
- R7: A new bus setting takes effect only after the bus period in progress has completed. A new first-stage setting takes effect only at a rising source edge that ends a one-and-a-half period, which is every second output period.
- R8: While settings change, neither sys_clk nor bus_clk shows a high or low phase shorter than half a source period.
- R9: When wr_en is low, wr_data has no effect on the stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the configuration field |
| wr_data | input | 32 | Write data. Bit 3 selects the 1.5 stage; bits 2:0 hold log2 of the bus divider |
| rd_data | output | 32 | Readback of the configuration field, with upper bits zero |
| sys_clk | output | 1 | Output of the first stage |
| bus_clk | output | 1 | Output of the power-of-two stage |

## Verification
The bench applies all 16 settings in a scrambled order, so each first-stage mode is followed by bus settings both larger and smaller than the one before it. For each setting it measures the periods and high times of both clocks against values computed from the arithmetic. These measurements separate a wrong bus exponent, a wrong duty cycle and a missing one-and-a-half stage. Two writes are placed deliberately in the middle of an output period, one for the bus divider and one for the first stage. The edge times that follow show whether the change waits for the period boundary. Writes that carry junk in the reserved bits, and a write with the strobe low, show that only the low four bits are stored and only under the strobe.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

  localparam int BUS_SEL_W = 3;
  localparam int CFG_W     = BUS_SEL_W + 1;
  localparam int CNT_W     = (1 << BUS_SEL_W) - 1;

  typedef struct packed {
    logic                 div15;
    logic [BUS_SEL_W-1:0] bus_log;
  } cfg_t;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } ph_t;

  // index of the final system-clock cycle in one bus period: 2^lg - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [BUS_SEL_W-1:0] lg);
    logic [CNT_W:0] w;
    w     = '0;
    w[lg] = 1'b1;
    return w[CNT_W-1:0] - CNT_W'(1);
  endfunction

  // cycles spent high in one bus period: 2^(lg-1)
  function automatic logic [CNT_W-1:0] high_count(input logic [BUS_SEL_W-1:0] lg);
    logic [CNT_W:0] w;
    w     = '0;
    w[lg] = 1'b1;
    return w[CNT_W:1];
  endfunction

endpackage

// File: rtl/clkpre_cfg.sv
module clkpre_cfg
  import clkpre_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  src_clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CFG_W-1:0]      wr_field,
  output logic [DATA_W-1:0]     rd_data,
  output cfg_t                  cfg
);

  localparam int PAD_W = DATA_W - CFG_W;

  cfg_t cfg_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_t'(wr_field);
  end

  assign cfg     = cfg_q;
  assign rd_data = {{PAD_W{1'b0}}, cfg_q};

  AST_WRITE_READBACK: assert property (@(posedge src_clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{PAD_W{1'b0}}, $past(wr_field)}); // R6

  AST_HOLD_NO_STROBE: assert property (@(posedge src_clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R9

endmodule

// File: rtl/clkpre_div15.sv
module clkpre_div15
  import clkpre_pkg::*;
(
  input  logic src_clk,
  input  logic rst_n,
  input  logic want_div15,
  output logic sys_clk
);

  ph_t  ph;
  logic tgl_rise;
  logic tgl_fall;
  logic active;
  logic out15;
  logic swap_ok;

  // a mode change is safe at a falling source edge when the divided
  // output is low and the next rising source edge starts a fresh period
  assign swap_ok = !active || (ph == PH_C);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_C;
      tgl_rise <= 1'b0;
    end else if (!active) begin
      ph       <= PH_C;
      tgl_rise <= tgl_fall;
    end else begin
      case (ph)
        PH_A:    ph <= PH_B;
        PH_B:    ph <= PH_C;
        default: ph <= PH_A;
      endcase
      if (ph != PH_A) tgl_rise <= ~tgl_rise;
    end
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tgl_fall <= 1'b0;
    end else begin
      if (swap_ok) active <= want_div15;
      if (!active)            tgl_fall <= tgl_rise;
      else if (ph != PH_C)    tgl_fall <= ~tgl_fall;
    end
  end

  assign out15   = tgl_rise ^ tgl_fall;
  assign sys_clk = active ? out15 : src_clk;

  AST_MODE_SWAP_LOW: assert property (@(negedge src_clk) disable iff (!rst_n)
    (swap_ok && (want_div15 != active)) |-> !out15); // R8

  AST_IDLE_QUIET: assert property (@(posedge src_clk) disable iff (!rst_n)
    !active |-> !out15); // R3

endmodule

// File: rtl/clkpre_pow2.sv
module clkpre_pow2
  import clkpre_pkg::*;
(
  input  logic                 sys_clk,
  input  logic                 rst_n,
  input  logic [BUS_SEL_W-1:0] want_log,
  output logic                 bus_clk
);

  logic [BUS_SEL_W-1:0] ap_log;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     nxt;
  logic [CNT_W-1:0]     lim;
  logic [CNT_W-1:0]     hi_n;
  logic                 pass;
  logic                 bound;
  logic                 last_q;
  logic                 bus_q;

  assign pass  = (ap_log == '0);
  assign lim   = last_count(ap_log);
  assign hi_n  = high_count(ap_log);
  assign bound = pass || (cnt == lim);
  assign nxt   = last_q ? '0 : cnt + CNT_W'(1);

  // settings are adopted in the low phase of the final cycle of a period
  always_ff @(negedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_log <= '0;
      last_q <= 1'b1;
    end else begin
      last_q <= bound;
      if (bound) ap_log <= want_log;
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      bus_q <= 1'b0;
    end else if (pass) begin
      cnt   <= '0;
      bus_q <= 1'b0;
    end else begin
      cnt   <= nxt;
      bus_q <= (nxt < hi_n);
    end
  end

  assign bus_clk = pass ? sys_clk : bus_q;

  AST_BUS_SWAP_LOW: assert property (@(negedge sys_clk) disable iff (!rst_n)
    (bound && (want_log != ap_log)) |-> !bus_q); // R8

  AST_COUNT_IN_PERIOD: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!pass && !last_q) |-> (cnt < lim)); // R7

endmodule

// File: rtl/sysbus_prescaler.sv
module sysbus_prescaler
  import clkpre_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              src_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_clk,
  output logic              bus_clk
);

  cfg_t cfg;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

  clkpre_cfg #(.DATA_W(DATA_W)) u_cfg (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_field (wr_data[CFG_W-1:0]),
    .rd_data  (rd_data),
    .cfg      (cfg)
  );

  clkpre_div15 u_div15 (
    .src_clk    (src_clk),
    .rst_n      (rst_n),
    .want_div15 (cfg.div15),
    .sys_clk    (sys_clk)
  );

  clkpre_pow2 u_pow2 (
    .sys_clk  (sys_clk),
    .rst_n    (rst_n),
    .want_log (cfg.bus_log),
    .bus_clk  (bus_clk)
  );

  AST_RESERVED_ZERO: assert property (@(posedge src_clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CFG_W] == '0); // R6

endmodule

// File: tb/sim_sysbus_prescaler.sv
module sim_sysbus_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic        src_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_clk;
  logic        bus_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint sys_t [64];
  longint bus_t [64];
  int     sys_n = 0;
  int     bus_n = 0;
  longint sys_f = 0;
  longint bus_f = 0;
  longint sys_prev = -1;
  longint bus_prev = -1;
  int     glitches = 0;

  sysbus_prescaler u0 (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .sys_clk (sys_clk),
    .bus_clk (bus_clk)
  );

  always #HALF src_clk = ~src_clk;

  always @(sys_clk) begin
    if (rst_n) begin
      if (sys_prev >= 0 && ($time - sys_prev) < HALF) glitches++;
      sys_prev = $time;
    end
    if (sys_clk) begin sys_t[sys_n % 64] = $time; sys_n++; end
    else sys_f = $time;
  end

  always @(bus_clk) begin
    if (rst_n) begin
      if (bus_prev >= 0 && ($time - bus_prev) < HALF) glitches++;
      bus_prev = $time;
    end
    if (bus_clk) begin bus_t[bus_n % 64] = $time; bus_n++; end
    else bus_f = $time;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge src_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge src_clk);
    wr_en   = 1'b0;
    wr_data = 32'hC0DE_F00F;
  endtask

  function automatic longint sys_rise(input int back);
    return sys_t[(sys_n - back) % 64];
  endfunction

  function automatic longint bus_rise(input int back);
    return bus_t[(bus_n - back) % 64];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    rst_n = 1'b1;
    #2;
    chk("R1 readback after reset", rd_data, 0);
    chk("R1 sys low with src", sys_clk, 0);
    chk("R1 bus low with sys", bus_clk, 0);
    @(posedge src_clk);
    #2;
    chk("R1 sys high with src", sys_clk, 1);
    chk("R1 bus high with sys", bus_clk, 1);

    // sweep every setting in a scrambled order
    for (int i = 0; i < 16; i++) begin
      int     c;
      int     k;
      int     sp;
      longint bp_exp;
      longint bh_exp;
      longint sr;
      c = (i * 7 + 3) % 16;
      k = c % 8;
      sp = (c >= 8) ? (CLK_PERIOD * 3 / 2) : CLK_PERIOD;
      bp_exp = longint'(sp) << k;
      bh_exp = (k == 0) ? HALF : (longint'(sp) << (k - 1));
      wr({28'h5A5A5A5, 4'(c)});
      chk("R6 readback of field, reserved zero", rd_data, c);
      repeat (6) @(posedge bus_clk);
      #1;
      chk((c >= 8) ? "R2 sys period" : "R3 sys period",
          sys_rise(1) - sys_rise(2), sp);
      chk((k == 0) ? "R5 bus period" : "R4 bus period",
          bus_rise(1) - bus_rise(2), bp_exp);
      if (k == 0) chk("R5 bus rise equals sys rise", bus_rise(1), sys_rise(1));
      sr = sys_rise(1);
      if (c < 8) chk("R3 sys rise on src rise", sr % CLK_PERIOD, HALF);
      @(negedge bus_clk);
      #1;
      chk((k == 0) ? "R5 bus high time" : "R4 bus high time",
          bus_f - bus_rise(1), bh_exp);
      @(negedge sys_clk);
      #1;
      chk((c >= 8) ? "R2 sys high time" : "R3 sys high time",
          sys_f - sys_rise(1), HALF);
    end

    // R9: data presented without the strobe is ignored
    wr(32'h0000_0005);
    @(negedge src_clk);
    wr_data = 32'hFFFF_FFFA;
    @(negedge src_clk);
    @(negedge src_clk);
    chk("R9 no write without strobe", rd_data, 5);

    // R7: bus change mid period waits for the period end
    wr(32'h0000_0003);
    repeat (6) @(posedge bus_clk);
    wr(32'h0000_0001);
    repeat (3) @(posedge bus_clk);
    #1;
    chk("R7 old bus period completes", bus_rise(3) - bus_rise(4), 8 * CLK_PERIOD);
    chk("R7 new bus period follows", bus_rise(2) - bus_rise(3), 2 * CLK_PERIOD);

    // R7: first stage change waits for an aligned period end
    wr(32'h0000_0008);
    repeat (6) @(posedge sys_clk);
    do @(posedge sys_clk); while (($time % CLK_PERIOD) != HALF);
    wr(32'h0000_0000);
    repeat (3) @(posedge sys_clk);
    #1;
    chk("R7 sys 1.5 period kept", sys_rise(3) - sys_rise(4), 15 * CLK_PERIOD / 10);
    chk("R7 sys 1.5 period kept to boundary", sys_rise(2) - sys_rise(3), 15 * CLK_PERIOD / 10);
    chk("R7 sys undivided after boundary", sys_rise(1) - sys_rise(2), CLK_PERIOD);

    chk("R8 no short clock phase", glitches, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule